// File: doc/BRIEF.md
# Template-Addressed Jump Resolver

This unit works out where a pattern-addressed jump lands. The jump does not carry a numeric target. Instead, the instruction is followed by a short run of marker opcodes, and that run is the template. The engine receives the jump's address through a start strobe. It first reads the template out of instruction memory. It then walks forward through memory, one word per cycle, looking for another place where the same marker sequence occurs. When it finds one, it reports the address just past that copy as the new program counter.

Instruction memory is reached through a plain synchronous read port with a fixed one-cycle latency. The engine drives an address and a read enable, and the opcode comes back on the next cycle. The port has no handshake and no back-pressure: the memory must answer every read on time. The start, done and found pins are plain control pins. The new PC and found flag keep their values until the next result is reported.

Top module: `tmpl_jump_engine`

## Requirements
- R1: Marker opcodes are 4'h1 (kind A) and 4'h2 (kind B). The template is the unbroken run of markers that begins at J+1, where J is the jump address. The order of A and B within the template matters.
- R2: The template holds at most MAX_TPL (8) markers. A marker beyond the cap is not part of the template, and scanning starts at J+1+MAX_TPL.
- R3: If the word at J+1 is not a marker, no scan takes place. done_o pulses two cycles after the start edge, with found_o=0 and pc_o=J+1.
- R4: For a template of length L, the scan reads one word per cycle from S=J+L+1 upward, wrapping modulo 64. A match is any L consecutive scanned words that equal the template. Matches that overlap a partial earlier match are still found.
- R5: On a match, found_o=1 and pc_o is the address after the last word of the match, taken modulo 64. This also holds when the match straddles address 63/0.
- R6: The scan covers exactly 64-L words, so the jump's own template is never matched. If nothing matches, found_o=0 and pc_o=J+L+1.
- R7: Read data arrives one cycle after its address. done_o rises N edges after the start edge, counting the start edge as edge 0. N=c+m+3, where c=MAX_TPL if L=MAX_TPL and c=L+1 otherwise, and m is the 0-based index of the final scanned word.
- R8: done_o is high for exactly one cycle. pc_o and found_o hold their values until the next done_o.
- R9: A start_i that arrives while a search is running is ignored. The result is the one for the original jump address.
- R10: After reset, done_o=0, found_o=0 and pc_o=0. A start accepted in idle reads J+1 on the next cycle, with mem_rd_o high for as long as a search is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| jump_addr_i | input | ADDR_W | Address of the jump instruction |
| mem_rd_o | output | 1 | Read enable, high while a search runs |
| mem_addr_o | output | ADDR_W | Instruction memory read address |
| mem_data_i | input | OP_W | Opcode returned one cycle after its address |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A matching template was located |
| pc_o | output | ADDR_W | Resolved program counter |

## Verification
The bench targets several corner cases, and each one catches a specific kind of design error:
- A template of the form A A B placed behind a run of three A's. A matcher that simply restarts on a mismatch skips this match.
- A copy that straddles the top of memory. A scan that does not wrap misses it.
- A template that has only its own copy in memory. A pass that is one word too long reports its own template as the match.
- A nine-marker run after the jump. Ignoring the cap changes both the template and the scan start.
- A reversed B A decoy, which traps a design that compares markers without regard to order.
- A zero-length template, whose fall-through address and latency are checked exactly.
- A start pulse injected in the middle of a search. A design that restarts on it ends at a different time or returns a different PC.

// File: rtl/tjs_pkg.sv
package tjs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TPL  = 2'd1,
    ST_SCAN = 2'd2
  } tjs_state_e;
endpackage

// File: rtl/tjs_marker_decode.sv
module tjs_marker_decode #(
  parameter int OP_W = 4,
  parameter logic [OP_W-1:0] MARK_A = 4'h1,
  parameter logic [OP_W-1:0] MARK_B = 4'h2
) (
  input  logic [OP_W-1:0] op_i,
  output logic            is_mark_o,
  output logic            kind_o
);
  always_comb begin
    is_mark_o = (op_i == MARK_A) || (op_i == MARK_B);
    kind_o    = (op_i == MARK_B);
  end
endmodule

// File: rtl/tjs_tpl_store.sv
module tjs_tpl_store #(
  parameter int MAX_TPL = 8,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               push_i,
  input  logic               kind_i,
  output logic [MAX_TPL-1:0] tpl_o,
  output logic [LEN_W-1:0]   len_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      tpl_o <= '0;
      len_o <= '0;
    end else if (push_i) begin
      tpl_o <= (tpl_o << 1) | MAX_TPL'(kind_i);
      len_o <= len_o + LEN_W'(1);
    end
  end
endmodule

// File: rtl/tjs_match_window.sv
module tjs_match_window #(
  parameter int MAX_TPL = 8,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic               is_mark_i,
  input  logic               kind_i,
  input  logic [MAX_TPL-1:0] tpl_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               hit_o
);
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_TPL);

  logic [MAX_TPL-1:0] win_q, win_d, mask;
  logic [LEN_W-1:0]   run_q, run_d;

  always_comb begin
    for (int i = 0; i < MAX_TPL; i++) mask[i] = (LEN_W'(i) < len_i);
    win_d = (win_q << 1) | MAX_TPL'(kind_i);
    if (!is_mark_i)      run_d = '0;
    else if (run_q == CAP) run_d = CAP;
    else                 run_d = run_q + LEN_W'(1);
    hit_o = step_i && is_mark_i && (len_i != '0) && (run_d >= len_i)
            && (((win_d ^ tpl_i) & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      win_q <= '0;
      run_q <= '0;
    end else if (step_i) begin
      win_q <= win_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/tmpl_jump_engine.sv
module tmpl_jump_engine
  import tjs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int OP_W    = 4,
  parameter int MAX_TPL = 8,
  parameter logic [OP_W-1:0] MARK_A = 4'h1,
  parameter logic [OP_W-1:0] MARK_B = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] jump_addr_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [OP_W-1:0]   mem_data_i,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN_W = $clog2(MAX_TPL + 1);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [LEN_W-1:0] LAST_SLOT = LEN_W'(MAX_TPL - 1);

  tjs_state_e         st;
  logic [ADDR_W-1:0]  base, ptr;
  logic               dv;
  logic [CNT_W-1:0]   cnt;
  logic               is_mark, kind, hit;
  logic [MAX_TPL-1:0] tpl;
  logic [LEN_W-1:0]   tlen, fin_len;
  logic               accept, tpl_push, tpl_end, scan_step, scan_last;
  logic [ADDR_W-1:0]  scan_start;

  tjs_marker_decode #(.OP_W(OP_W), .MARK_A(MARK_A), .MARK_B(MARK_B)) u_dec (
    .op_i(mem_data_i), .is_mark_o(is_mark), .kind_o(kind)
  );

  tjs_tpl_store #(.MAX_TPL(MAX_TPL), .LEN_W(LEN_W)) u_tpl (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .push_i(tpl_push),
    .kind_i(kind), .tpl_o(tpl), .len_o(tlen)
  );

  tjs_match_window #(.MAX_TPL(MAX_TPL), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clear_i(tpl_end), .step_i(scan_step),
    .is_mark_i(is_mark), .kind_i(kind), .tpl_i(tpl), .len_i(tlen), .hit_o(hit)
  );

  always_comb begin
    accept     = (st == ST_IDLE) && start_i;
    tpl_push   = (st == ST_TPL) && dv && is_mark;
    tpl_end    = (st == ST_TPL) && dv && (!is_mark || tlen == LAST_SLOT);
    fin_len    = is_mark ? tlen + LEN_W'(1) : tlen;
    scan_start = base + ADDR_W'(fin_len) + ADDR_W'(1);
    scan_step  = (st == ST_SCAN) && dv;
    scan_last  = cnt == (CNT_W'(DEPTH) - CNT_W'(tlen) - CNT_W'(1));
    mem_rd_o   = (st != ST_IDLE);
    mem_addr_o = ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      base    <= '0;
      ptr     <= '0;
      dv      <= 1'b0;
      cnt     <= '0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      pc_o    <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            base <= jump_addr_i;
            ptr  <= jump_addr_i + ADDR_W'(1);
            dv   <= 1'b0;
            st   <= ST_TPL;
          end
        end
        ST_TPL: begin
          ptr <= ptr + ADDR_W'(1);
          dv  <= 1'b1;
          if (tpl_end) begin
            if (fin_len == '0) begin
              done_o  <= 1'b1;
              found_o <= 1'b0;
              pc_o    <= base + ADDR_W'(1);
              st      <= ST_IDLE;
            end else begin
              ptr <= scan_start;
              dv  <= 1'b0;
              cnt <= '0;
              st  <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          ptr <= ptr + ADDR_W'(1);
          dv  <= 1'b1;
          if (dv) begin
            cnt <= cnt + CNT_W'(1);
            if (hit) begin
              done_o  <= 1'b1;
              found_o <= 1'b1;
              pc_o    <= ptr;
              st      <= ST_IDLE;
            end else if (scan_last) begin
              done_o  <= 1'b1;
              found_o <= 1'b0;
              pc_o    <= base + ADDR_W'(tlen) + ADDR_W'(1);
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmpl_jump_engine_chk.sv
module tmpl_jump_engine_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] jump_addr_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] pc_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(pc_o) && $stable(found_o)));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_o && start_i) |=>
      (mem_rd_o && mem_addr_o == ADDR_W'($past(jump_addr_i) + 1'b1)));

  // R10
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_rd_o);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && start_i) |=> (mem_rd_o || done_o));
endmodule

bind tmpl_jump_engine tmpl_jump_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .jump_addr_i(jump_addr_i),
  .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .done_o(done_o),
  .found_o(found_o), .pc_o(pc_o)
);

// File: tb/tmpl_jump_engine_test.sv
module tmpl_jump_engine_test;
  localparam int AW = 6;
  localparam int D  = 64;
  localparam int MX = 8;
  localparam logic [3:0] OA = 4'h1, OB = 4'h2, OF = 4'h7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] jaddr = '0, maddr, pc;
  logic mrd, done, found;
  logic [3:0] mdata = '0;
  logic [3:0] mem [D];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  always @(posedge clk) mdata <= mem[maddr];

  tmpl_jump_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .jump_addr_i(jaddr),
    .mem_rd_o(mrd), .mem_addr_o(maddr), .mem_data_i(mdata),
    .done_o(done), .found_o(found), .pc_o(pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit mk(input logic [3:0] op);
    return op == OA || op == OB;
  endfunction

  task automatic fill();
    for (int i = 0; i < D; i++) mem[i] = OF;
  endtask

  task automatic model(input int j, output int epc, output int ef, output int lat);
    int l, c, s;
    bit ok;
    l = 0;
    while (l < MX && mk(mem[(j + 1 + l) % D])) l++;
    if (l == 0) begin
      epc = (j + 1) % D; ef = 0; lat = 2;
      return;
    end
    c = (l == MX) ? MX : l + 1;
    s = j + l + 1;
    for (int m = l - 1; m <= D - l - 1; m++) begin
      ok = 1;
      for (int i = 0; i < l; i++)
        if (mem[(s + m - l + 1 + i) % D] != mem[(j + 1 + i) % D]) ok = 0;
      if (ok) begin
        epc = (s + m + 1) % D; ef = 1; lat = c + m + 3;
        return;
      end
    end
    epc = (j + l + 1) % D; ef = 0; lat = c + (D - l - 1) + 3;
  endtask

  task automatic run(input int j, input bit inject, input string req);
    int epc, ef, lat;
    int held;
    model(j, epc, ef, lat);
    @(negedge clk); start = 1'b1; jaddr = AW'(j);
    @(negedge clk); start = 1'b0;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (inject && n == 3) begin start = 1'b1; jaddr = AW'(j + 17); end
      else start = 1'b0;
      // R7: done exactly at edge lat; R8: single-cycle pulse
      chk(done == (n == lat), {req, " R7 done timing"}, int'(done), int'(n == lat));
      if (n == lat) begin
        chk(pc == AW'(epc), {req, " pc"}, int'(pc), epc);
        chk(found == ef[0], {req, " found"}, int'(found), ef);
        held = int'(pc);
      end
      if (n == lat + 1)
        chk(int'(pc) == held, "R8 pc held", int'(pc), held);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(found == 1'b0, "R10 reset found", int'(found), 0);
    chk(pc == '0, "R10 reset pc", int'(pc), 0);
    rst_n = 1'b1;

    // R5 basic: A B at 1-2, copy at 5-6, resume at 7
    fill(); mem[1] = OA; mem[2] = OB; mem[5] = OA; mem[6] = OB;
    run(0, 0, "R5 basic");

    // R3 zero-length template
    fill(); run(10, 0, "R3 zero length");

    // R6 no other copy: own template never matched
    fill(); mem[21] = OB; mem[22] = OB; mem[40] = OB;
    run(20, 0, "R6 not found");

    // R4 overlapping prefix A A A B after wrap
    fill(); mem[61] = OA; mem[62] = OA; mem[63] = OB;
    mem[9] = OA; mem[10] = OA; mem[11] = OA; mem[12] = OB;
    run(60, 0, "R4 overlap wrap");

    // R5 match straddling 63/0
    fill(); mem[31] = OB; mem[32] = OA; mem[63] = OB; mem[0] = OA;
    run(30, 0, "R5 straddle");

    // R2 cap: nine markers, only eight form the template
    fill();
    for (int i = 41; i <= 49; i++) mem[i] = OA;
    for (int i = 2; i <= 9; i++) mem[i] = OA;
    run(40, 0, "R2 cap");

    // R1 order matters: B A decoy before A B copy
    fill(); mem[1] = OA; mem[2] = OB; mem[10] = OB; mem[11] = OA;
    mem[20] = OA; mem[21] = OB;
    run(0, 0, "R1 order");

    // R9 start during search is ignored
    fill(); mem[21] = OB; mem[22] = OA; mem[50] = OB; mem[51] = OA;
    run(20, 1, "R9 busy start");

    // R6 long search with no copy, again with busy start
    fill(); mem[5] = OA;
    run(4, 1, "R6 R9 single marker");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule